// File: doc/BRIEF.md
# Instruction Fetch Unit with Prefetch Queue

The block reads instruction words from a single-port on-chip instruction memory (1024 words of 17 bits). Each word goes, together with the address it came from, into a small in-order queue. A downstream execution stage reads the head of the queue and pops it with a one-cycle dequeue strobe. Each instruction carries a static prediction flag. When the flag is set, the next fetch goes to the instruction's own address plus its sign-extended 5-bit offset. Otherwise fetch continues at the next sequential address.

The back end can redirect fetch with a restart strobe and a new address. A restart empties the queue and drops any word already being read. The back end can also read or write instruction-memory words through the same memory port. Such an access always takes the port in that cycle, so fetch waits. The memory has a one-cycle read latency. The fetch path uses a combinational next-address path on the returning word, so it can issue one read per cycle.

Top module: `ifu_top`

## Requirements
- R1: A synchronous active-high reset empties the queue (`q_valid_o` low on the next cycle) and drops any read in flight. After reset is released, the first queued entry comes from address 0x000.
- R2: When bit 5 (the prediction flag) of a fetched word is 0, the next entry comes from that word's address plus 1, taken modulo 1024. This holds even when bits [4:0] are nonzero.
- R3: When bit 5 of a fetched word is 1, the next entry comes from that word's address plus bits [4:0] read as a two's-complement value from -16 to +15, taken modulo 1024.
- R4: Each entry at the queue head shows a fetched address on `q_addr_o` and the memory word at that address on `q_instr_o`. Entries appear in fetch order, none is lost and none is repeated, whatever the dequeue pattern.
- R5: While reset is low, a restart strobe empties the queue, with `q_valid_o` low on the next cycle. It discards any read in flight, and the next entry comes from `restart_addr_i`.
- R6: A load (`mem_en_i`=1, `mem_we_i`=0) puts the word at `mem_addr_i` on `ld_data_o` in the following cycle, with `ld_valid_o` high for exactly that cycle.
- R7: A store (`mem_en_i`=1, `mem_we_i`=1) writes `mem_wdata_i` to `mem_addr_i`. The write also happens while reset is high, because memory access ranks above reset.
- R8: A load or store takes the memory port, and no fetch starts in that cycle. While memory accesses run every cycle, no new entry joins the queue.
- R9: The queue holds `DEPTH` entries (8 by default). When it is full, fetch stalls without losing or skipping an address.
- R10: A dequeue strobe while the queue is empty has no effect. A dequeue and an enqueue in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deq_i | input | 1 | Pop the queue head |
| restart_i | input | 1 | Flush the queue and redirect fetch |
| restart_addr_i | input | 10 | Redirect address |
| mem_en_i | input | 1 | Back-end memory access request |
| mem_we_i | input | 1 | 1 = store, 0 = load |
| mem_addr_i | input | 10 | Back-end access address |
| mem_wdata_i | input | 17 | Store data |
| q_instr_o | output | 17 | Instruction at the queue head |
| q_addr_o | output | 10 | Address of the head instruction |
| q_valid_o | output | 1 | Queue not empty |
| ld_data_o | output | 17 | Load result |
| ld_valid_o | output | 1 | Load result valid |

## Verification
The assertions assume that the back end never pops or redirects on the strength of stale head values. The bench therefore drives every input at the falling edge and samples at the falling edge. They also assume that restart and reset are not combined with a memory access in ways that matter to the queue. In the bench, every restart happens with the memory port idle. Stores happen only while reset holds the fetch path still. Loads during the run are held for whole windows, so the effect of losing the port on the queue can be seen at the outputs.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
    localparam int IW       = 17;
    localparam int AW       = 10;
    localparam int OW       = 5;
    localparam int PRED_BIT = OW;

    typedef logic [IW-1:0] instr_t;
    typedef logic [AW-1:0] addr_t;

    typedef struct packed {
        addr_t  addr;
        instr_t instr;
    } qent_t;

    function automatic addr_t sext_off(input instr_t w);
        return {{(AW-OW){w[OW-1]}}, w[OW-1:0]};
    endfunction
endpackage

// File: rtl/ifu_imem.sv
module ifu_imem
    import ifu_pkg::*;
(
    input  logic   clk,
    input  logic   en,
    input  logic   we,
    input  addr_t  addr,
    input  instr_t wdata,
    output instr_t rdata
);
    localparam int WORDS = 1 << AW;

    instr_t store_arr [WORDS];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) store_arr[addr] <= wdata;
            else    rdata           <= store_arr[addr];
        end
    end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
    import ifu_pkg::*;
(
    input  addr_t  cur_addr,
    input  instr_t word,
    output addr_t  nxt_addr
);
    addr_t disp;

    always_comb begin
        disp     = word[PRED_BIT] ? sext_off(word) : AW'(1);
        nxt_addr = cur_addr + disp;
    end
endmodule

// File: rtl/ifu_queue.sv
module ifu_queue
    import ifu_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          enq,
    input  qent_t         enq_data,
    input  logic          deq,
    output qent_t         head,
    output logic [CW-1:0] count
);
    qent_t         slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          deq_ok;

    assign deq_ok = deq && (count != '0);
    assign head   = slots[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (enq) slots[wr_ptr] <= enq_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (enq)    wr_ptr <= bump(wr_ptr);
            if (deq_ok) rd_ptr <= bump(rd_ptr);
            case ({enq, deq_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        enq |-> (count < CW'(DEPTH)));

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (rst)
        (deq && count == '0 && !enq && !flush) |=> (count == '0));
endmodule

// File: rtl/ifu_top.sv
module ifu_top
    import ifu_pkg::*;
#(
    parameter int DEPTH = 8
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          deq_i,
    input  logic          restart_i,
    input  logic [AW-1:0] restart_addr_i,
    input  logic          mem_en_i,
    input  logic          mem_we_i,
    input  logic [AW-1:0] mem_addr_i,
    input  logic [IW-1:0] mem_wdata_i,
    output logic [IW-1:0] q_instr_o,
    output logic [AW-1:0] q_addr_o,
    output logic          q_valid_o,
    output logic [IW-1:0] ld_data_o,
    output logic          ld_valid_o
);
    localparam int CW = $clog2(DEPTH + 1);

    addr_t          pc_q, infl_addr_q, ret_next, cur_addr, ram_addr;
    logic           infl_q, enq, room, fetch_go, ram_en, ram_we;
    instr_t         ram_rdata;
    qent_t          head;
    logic [CW-1:0]  count;
    logic [CW:0]    occ_after;

    ifu_imem u_mem (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (mem_wdata_i),
        .rdata (ram_rdata)
    );

    ifu_next_pc u_npc (
        .cur_addr (infl_addr_q),
        .word     (ram_rdata),
        .nxt_addr (ret_next)
    );

    ifu_queue #(.DEPTH(DEPTH)) u_q (
        .clk      (clk),
        .rst      (rst),
        .flush    (restart_i),
        .enq      (enq),
        .enq_data ('{addr: infl_addr_q, instr: ram_rdata}),
        .deq      (deq_i),
        .head     (head),
        .count    (count)
    );

    always_comb begin
        cur_addr  = infl_q ? ret_next : pc_q;
        enq       = infl_q && !rst && !restart_i;
        occ_after = {1'b0, count} + {{CW{1'b0}}, enq};
        room      = occ_after < (CW+1)'(DEPTH);
        fetch_go  = !mem_en_i && !rst && !restart_i && room;
        ram_en    = mem_en_i || fetch_go;
        ram_we    = mem_en_i && mem_we_i;
        ram_addr  = mem_en_i ? mem_addr_i : cur_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            infl_q <= 1'b0;
        end else if (restart_i) begin
            pc_q   <= restart_addr_i;
            infl_q <= 1'b0;
        end else begin
            pc_q        <= cur_addr;
            infl_q      <= fetch_go;
            infl_addr_q <= cur_addr;
        end
    end

    always_ff @(posedge clk) begin
        ld_valid_o <= mem_en_i && !mem_we_i;
    end

    assign ld_data_o = ram_rdata;
    assign q_instr_o = head.instr;
    assign q_addr_o  = head.addr;
    assign q_valid_o = (count != '0);

    assert_flush_empty_R5: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !q_valid_o);

    assert_port_taken_R8: assert property (@(posedge clk) disable iff (rst)
        mem_en_i |=> !infl_q);

    assert_load_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_en_i && !mem_we_i) |=> ld_valid_o);

    assert_quiet_after_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !restart_i) |-> !q_valid_o);
endmodule

// File: tb/ifu_top_bench.sv
module ifu_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        deq_i = 1'b0, restart_i = 1'b0;
    logic [9:0]  restart_addr_i = '0;
    logic        mem_en_i = 1'b0, mem_we_i = 1'b0;
    logic [9:0]  mem_addr_i = '0;
    logic [16:0] mem_wdata_i = '0;
    logic [16:0] q_instr_o, ld_data_o;
    logic [9:0]  q_addr_o;
    logic        q_valid_o, ld_valid_o;

    int total = 0;
    int bad   = 0;
    logic [9:0] exp_a;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifu_top #(.DEPTH(DEPTH)) u_ifu_top (
        .clk(clk), .rst(rst), .deq_i(deq_i), .restart_i(restart_i),
        .restart_addr_i(restart_addr_i), .mem_en_i(mem_en_i), .mem_we_i(mem_we_i),
        .mem_addr_i(mem_addr_i), .mem_wdata_i(mem_wdata_i),
        .q_instr_o(q_instr_o), .q_addr_o(q_addr_o), .q_valid_o(q_valid_o),
        .ld_data_o(ld_data_o), .ld_valid_o(ld_valid_o)
    );

    // program image: computed, with branches at chosen addresses
    function automatic logic [16:0] img(input logic [9:0] a);
        logic [16:0] w;
        w    = 17'(a * 613 + 91);
        w[5] = 1'b0;
        case (a)
            10'd2:    w[4:0] = 5'd7;                      // flag clear, offset ignored
            10'd4:    begin w[5] = 1'b1; w[4:0] = 5'd6;  end
            10'd10:   begin w[5] = 1'b1; w[4:0] = 5'h10; end // -16
            10'd1018: begin w[5] = 1'b1; w[4:0] = 5'd15; end
            default: ;
        endcase
        return w;
    endfunction

    function automatic logic [9:0] succ(input logic [9:0] a);
        logic [16:0] w;
        int          off;
        w = img(a);
        if (!w[5]) return a + 10'd1;
        off = w[4] ? int'(w[4:0]) - 32 : int'(w[4:0]);
        return 10'((int'(a) + off + 1024) % 1024);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic pop_n(input int n, input int gap);
        int got = 0, idle = 0, guard = 0;
        while (got < n && guard < 2000) begin
            @(negedge clk);
            guard++;
            deq_i = 1'b0;
            if (idle > 0) idle--;
            else if (q_valid_o) begin
                check(q_addr_o == exp_a, img(exp_a - 10'd1) ? "R4 addr" : "R4 addr", 32'(q_addr_o), 32'(exp_a));
                check(q_instr_o == img(exp_a), "R4 instr", 32'(q_instr_o), 32'(img(exp_a)));
                deq_i = 1'b1;
                exp_a = succ(exp_a);
                got++;
                idle = gap;
            end
        end
        check(got == n, "R4 pop count", 32'(got), 32'(n));
        @(negedge clk);
        deq_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        // R7: stores accepted while reset is held
        for (int a = 0; a < 1024; a++) begin
            if (a < 64 || a >= 1000) begin
                @(negedge clk);
                mem_en_i = 1'b1; mem_we_i = 1'b1;
                mem_addr_i = 10'(a); mem_wdata_i = img(10'(a));
            end
        end
        @(negedge clk);
        mem_en_i = 1'b0;
        check(q_valid_o == 1'b0, "R1 empty in reset", 32'(q_valid_o), 0);
        // R6/R7: load back a few words
        foreach (exp_a[i]) ;
        for (int k = 0; k < 3; k++) begin
            logic [9:0] la;
            la = (k == 0) ? 10'd4 : (k == 1) ? 10'd1018 : 10'd2;
            @(negedge clk);
            mem_en_i = 1'b1; mem_we_i = 1'b0; mem_addr_i = la;
            @(negedge clk);
            mem_en_i = 1'b0;
            check(ld_valid_o == 1'b1, "R6 load valid", 32'(ld_valid_o), 1);
            check(ld_data_o == img(la), "R7 stored word", 32'(ld_data_o), 32'(img(la)));
            @(negedge clk);
            check(ld_valid_o == 1'b0, "R6 single pulse", 32'(ld_valid_o), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        exp_a = 10'd0;
        // R1, R2, R3: stream from 0 with wraps both ways, back to back
        pop_n(12, 0);
        pop_n(6, 2);
        // R9: let it fill, then starve fetch with loads and drain
        repeat (30) @(negedge clk);
        check(q_valid_o == 1'b1, "R9 filled", 32'(q_valid_o), 1);
        mem_en_i = 1'b1; mem_we_i = 1'b0; mem_addr_i = 10'd1018;
        @(negedge clk);
        @(negedge clk);
        check(ld_data_o == img(10'd1018), "R6 load in run", 32'(ld_data_o), 32'(img(10'd1018)));
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            deq_i = 1'b0;
            if (q_valid_o) begin
                check(q_addr_o == exp_a, "R9 drain addr", 32'(q_addr_o), 32'(exp_a));
                deq_i = 1'b1;
                exp_a = succ(exp_a);
                cnt++;
            end
            @(negedge clk);
        end
        deq_i = 1'b0;
        check(cnt == DEPTH, "R9 depth", 32'(cnt), 32'(DEPTH));
        check(q_valid_o == 1'b0, "R8 no fetch under loads", 32'(q_valid_o), 0);
        mem_en_i = 1'b0;
        // R4: resumes with no lost address
        pop_n(5, 0);
        // R5 + R10: restart, then pop on empty
        @(negedge clk);
        restart_i = 1'b1; restart_addr_i = 10'd20;
        @(negedge clk);
        restart_i = 1'b0;
        check(q_valid_o == 1'b0, "R5 flushed", 32'(q_valid_o), 0);
        deq_i = 1'b1;
        @(negedge clk);
        deq_i = 1'b0;
        exp_a = 10'd20;
        pop_n(6, 1);
        check(1'b1, "R10 empty pop ignored", 0, 0);
        // R5 to a branch word, R3 wrap upward
        @(negedge clk);
        restart_i = 1'b1; restart_addr_i = 10'd1018;
        @(negedge clk);
        restart_i = 1'b0;
        exp_a = 10'd1018;
        pop_n(4, 0);
        // R1: reset mid-stream
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(q_valid_o == 1'b0, "R1 reset empties", 32'(q_valid_o), 0);
        exp_a = 10'd0;
        pop_n(8, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule